// File: doc/BRIEF.md
# Multicart Outer Bank Register

This block sits between a CPU-side inner bank mapper and the cartridge memory of a multi-game board. The inner mapper produces 8-bit program and character bank numbers for whichever game is running. This block narrows and offsets those numbers so that each game sees only its own slice of one large program ROM and one large character ROM.

The configuration is four 8-bit registers that share one write port. Writes land in the 0x6000–0x7FFF window. A 2-bit pointer picks the register that takes each write, then steps to the next one. It wraps after the fourth register, so a menu program sets up a game with four stores in a row. A lock flag in the last register then shuts the port, so the selected game cannot reach another game's banks. Both bank outputs are pure logic of the registers and the inner bank numbers.

Top module: `outer_bank_top`

## Requirements
- R1: A write is accepted only when `cpuWr` is high and `cpuAddr[15:13]` equals 3'b011 (0x6000 to 0x7FFF inclusive). A write outside the window changes no register and does not move the write pointer.
- R2: Each accepted write stores `cpuData` into configuration register number *p*, where *p* is the write pointer. The pointer then advances by one modulo 4, so the fifth write after reset lands in register 0 again.
- R3: While bit 6 of register 3 is 1, every write to the window is ignored, and both outputs keep following only the inner bank inputs.
- R4: `prgBank` = (`innerPrg` AND NOT {2'b00, register 3 bits 5:0}) OR register 1.
- R5: When bit 3 of register 2 is 1, the masked character value is the low (register 2 bits 2:0 plus one) bits of `innerChr`, with all higher bits zero. A size field of 7 passes all eight bits.
- R6: When bit 3 of register 2 is 0, the masked character value is zero, whatever `innerChr` is.
- R7: `chrBank` = {1'b0, masked value} OR {1'b0, register 0} OR (register 2 bit 4 placed at `chrBank[8]`).
- R8: While `rstN` is low, all four registers and the write pointer clear. After reset, `prgBank` equals `innerPrg`, `chrBank` is zero, and the next accepted write goes to register 0.
- R9: Both outputs are combinational. A change on `innerPrg` or `innerChr` shows in the same cycle. A register write shows from the clock edge that stores it onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWr | input | 1 | CPU write strobe, one cycle per write |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| innerPrg | input | 8 | Program bank number from the inner mapper |
| innerChr | input | 8 | Character bank number from the inner mapper |
| prgBank | output | 8 | Final program bank |
| chrBank | output | 9 | Final character bank |

## Verification
The bench probes the window edges at 0x5FFF, 0x6000, 0x7FFF and 0x8000. A design that decoded the window loosely would move the pointer on a stray write, and every later register would then be shifted by one. It checks the pointer wrap on the fifth write. It also sets the lock and then issues more writes. A design that ignored the lock would let those writes through, and both outputs would jump to all-ones patterns. The character mask is driven at sizes 0, 3, 5, 6 and 7 and with the enable clear. An off-by-one in the mask width, or a mask that ignores the enable, shows up as wrong low bits of `chrBank`.

// File: rtl/outer_bank_pkg.sv
package outer_bank_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_REGS   = 4;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int LOCK_BIT   = 6;
  localparam int CHR_EN_BIT = 3;
  localparam int CHR_HI_BIT = 4;
  localparam int SIZE_W     = 3;
  localparam int PRG_MASK_W = 6;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrSel;
  } cfgWrCmd_t;
endpackage

// File: rtl/outer_bank_ctrl.sv
module outer_bank_ctrl
  import outer_bank_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int TAG_W   = 3,
  parameter logic [TAG_W-1:0] WIN_TAG = 3'b011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              locked,
  output cfgWrCmd_t         cmd
);
  logic             inWin;
  logic [IDX_W-1:0] wrIdx;

  assign inWin     = (cpuAddr[ADDR_W-1 -: TAG_W] == WIN_TAG);
  assign cmd.wrEn  = cpuWr && inWin && !locked;
  assign cmd.wrSel = wrIdx;

  always_ff @(posedge clk) begin
    if (!rstN)         wrIdx <= '0;
    else if (cmd.wrEn) wrIdx <= wrIdx + 1'b1;
  end

  // R2
  index_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn |=> wrIdx == $past(wrIdx) + 1'b1);
  // R1
  window_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1 -: TAG_W] != WIN_TAG) |=> $stable(wrIdx));
endmodule

// File: rtl/outer_bank_dp.sv
module outer_bank_dp
  import outer_bank_pkg::*;
#(
  parameter int INNER_W = 8,
  parameter int CHR_W   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgWrCmd_t          cmd,
  input  logic [REG_W-1:0]   wrData,
  input  logic [INNER_W-1:0] innerPrg,
  input  logic [INNER_W-1:0] innerChr,
  output logic               locked,
  output logic [INNER_W-1:0] prgBank,
  output logic [CHR_W-1:0]   chrBank
);
  localparam int FLAT_W = REG_W * NUM_REGS;

  logic [REG_W-1:0]   cfgRegs [NUM_REGS];
  logic [FLAT_W-1:0]  regFlat;
  logic [INNER_W-1:0] prgClear;
  logic [INNER_W-1:0] chrMask;
  logic [INNER_W-1:0] chrLow;
  logic [SIZE_W-1:0]  chrSize;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        cfgRegs[g] <= '0;
      else if (cmd.wrEn && cmd.wrSel == IDX_W'(g))
        cfgRegs[g] <= wrData;
    end
    assign regFlat[g*REG_W +: REG_W] = cfgRegs[g];
  end

  assign locked   = cfgRegs[3][LOCK_BIT];
  assign prgClear = INNER_W'(cfgRegs[3][PRG_MASK_W-1:0]);
  assign prgBank  = (innerPrg & ~prgClear) | INNER_W'(cfgRegs[1]);

  assign chrSize = cfgRegs[2][SIZE_W-1:0];
  always_comb begin
    if (cfgRegs[2][CHR_EN_BIT])
      chrMask = {INNER_W{1'b1}} >> (INNER_W - 1 - int'(chrSize));
    else
      chrMask = '0;
  end
  assign chrLow  = innerChr & chrMask;
  assign chrBank = CHR_W'(chrLow) | CHR_W'(cfgRegs[0])
                 | (CHR_W'(cfgRegs[2][CHR_HI_BIT]) << INNER_W);

  // R2
  store_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn |=> cfgRegs[$past(cmd.wrSel)] == $past(wrData));
  // R3
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(regFlat));
  // R4
  prg_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prgBank & INNER_W'(cfgRegs[1])) == INNER_W'(cfgRegs[1]));
  // R6
  chr_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRegs[2][CHR_EN_BIT] |-> chrBank[INNER_W-1:0] == INNER_W'(cfgRegs[0]));
endmodule

// File: rtl/outer_bank_top.sv
module outer_bank_top
  import outer_bank_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INNER_W = 8,
  parameter int CHR_W   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuWr,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [REG_W-1:0]   cpuData,
  input  logic [INNER_W-1:0] innerPrg,
  input  logic [INNER_W-1:0] innerChr,
  output logic [INNER_W-1:0] prgBank,
  output logic [CHR_W-1:0]   chrBank
);
  cfgWrCmd_t wrCmd;
  logic      locked;

  outer_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .locked(locked), .cmd(wrCmd)
  );

  outer_bank_dp #(.INNER_W(INNER_W), .CHR_W(CHR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(wrCmd), .wrData(cpuData),
    .innerPrg(innerPrg), .innerChr(innerChr), .locked(locked),
    .prgBank(prgBank), .chrBank(chrBank)
  );
endmodule

// File: tb/tb_outer_bank_top.sv
module tb_outer_bank_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuWr;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuData;
  logic [7:0]  innerPrg;
  logic [7:0]  innerChr;
  logic [7:0]  prgBank;
  logic [8:0]  chrBank;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  outer_bank_top dut (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .innerPrg(innerPrg), .innerChr(innerChr), .prgBank(prgBank), .chrBank(chrBank)
  );

  typedef struct packed {
    logic [7:0] r0, r1, r2, r3, ip, ic, eP;
    logic [8:0] eC;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hFF, 8'hA5, 9'h000},
    '{8'h00, 8'h00, 8'h08, 8'h00, 8'h3C, 8'hFF, 8'h3C, 9'h001},
    '{8'h80, 8'h40, 8'h0B, 8'h3F, 8'hFF, 8'h5A, 8'hC0, 9'h08A},
    '{8'h00, 8'h05, 8'h1F, 8'h0F, 8'h9A, 8'hC3, 8'h95, 9'h1C3},
    '{8'h30, 8'h00, 8'h14, 8'h00, 8'h12, 8'h77, 8'h12, 9'h130},
    '{8'h01, 8'h21, 8'h0D, 8'h20, 8'hE3, 8'hFE, 8'hE3, 9'h03F},
    '{8'h00, 8'h00, 8'h0E, 8'h00, 8'h00, 8'hFF, 8'h00, 9'h07F}
  };

  task automatic checkOut(input string req, input logic [7:0] eP, input logic [8:0] eC);
    checks++;
    if (prgBank !== eP || chrBank !== eC) begin
      errors++;
      $display("FAIL %s: prg=%h chr=%h expected prg=%h chr=%h", req, prgBank, chrBank, eP, eC);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cpuWr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    cpuWr = 1'b1; cpuAddr = a; cpuData = d;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cpuWr = 1'b0; cpuAddr = '0; cpuData = '0;
    innerPrg = 8'h5A; innerChr = 8'hFF;
    doReset();
    #1 checkOut("R8 reset state", 8'h5A, 9'h000);

    // table walk: R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      doReset();
      cpuWrite(16'h6000, VECS[i].r0);
      cpuWrite(16'h6001, VECS[i].r1);
      cpuWrite(16'h7000, VECS[i].r2);
      cpuWrite(16'h7FFF, VECS[i].r3);
      innerPrg = VECS[i].ip; innerChr = VECS[i].ic;
      #1 checkOut($sformatf("R4/R5/R6/R7 vector %0d", i), VECS[i].eP, VECS[i].eC);
    end

    // R1: writes just outside the window are ignored
    doReset();
    innerPrg = 8'h11; innerChr = 8'hFF;
    cpuWrite(16'h5FFF, 8'h77);
    cpuWrite(16'h8000, 8'h77);
    #1 checkOut("R1 outside window no effect", 8'h11, 9'h000);
    cpuWrite(16'h6000, 8'h22);
    #1 checkOut("R1 pointer not moved by stray writes", 8'h11, 9'h022);
    cpuWrite(16'h7FFF, 8'h03);
    #1 checkOut("R1 upper window edge accepted", 8'h13, 9'h022);
    cpuWrite(16'h6000, 8'h00);
    cpuWrite(16'h6000, 8'h00);
    // R2: fifth write wraps to register 0
    cpuWrite(16'h6123, 8'h44);
    #1 checkOut("R2 pointer wrap to register 0", 8'h13, 9'h044);

    // R9: combinational paths and write timing
    doReset();
    cpuWrite(16'h6000, 8'h00);
    cpuWrite(16'h6000, 8'h00);
    cpuWrite(16'h6000, 8'h0F);
    innerPrg = 8'h81; innerChr = 8'h3C;
    #1 checkOut("R9 inner change same cycle", 8'h81, 9'h1FF & {1'b0, 8'h3C & 8'hFF});
    cpuWr = 1'b1; cpuAddr = 16'h6000; cpuData = 8'h07;
    #1 checkOut("R9 no change before write edge", 8'h81, 9'h03C);
    @(negedge clk);
    cpuWr = 1'b0;
    #1 checkOut("R9 write visible after edge", 8'h80, 9'h03C);

    // R3: lock bit blocks later writes
    doReset();
    innerPrg = 8'h66; innerChr = 8'hAA;
    cpuWrite(16'h6000, 8'h00);
    cpuWrite(16'h6000, 8'h00);
    cpuWrite(16'h6000, 8'h00);
    cpuWrite(16'h6000, 8'h40);
    for (int k = 0; k < 4; k++) cpuWrite(16'h6000, 8'hFF);
    #1 checkOut("R3 locked writes ignored", 8'h66, 9'h000);

    // R8: reset clears lock and pointer
    doReset();
    cpuWrite(16'h6000, 8'h5C);
    #1 checkOut("R8 reset clears lock and pointer", 8'h66, 9'h05C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule